// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between a 16-bit CPU address bus and the memories of a sound-playback system. Every memory access is routed to one of three destinations: the general read/write RAM, a banked ROM image, or one of two wavetable sound chips. The lower half and the top quarter of the address space are plain RAM. The quarter from 8000h to BFFFh is a window whose contents depend on the bank registers held inside the mapper.

Two mapping schemes are selected by the most significant bit of the bank-info configuration byte. In the single-window scheme the whole 16 KB window shows one bank, and the bank is chosen through an I/O port write. In the dual-window scheme each 8 KB half has its own bank, and the bank is chosen by writing to fixed memory addresses inside the window. Sound-chip register writes are overlaid on the window in both schemes. A bank number outside the configured range leaves the window on the initial RAM area. An extra RAM-mode flag makes the single-window scheme keep that RAM area fully writable.

The routing outputs are combinational from the bus and the bank registers. Bank registers change on the clock edge that samples the select write, so the new bank applies from the next cycle on.

Top module: `bank_window_mapper`

## Requirements
- R1: Any access with cpu_addr[15:14] != 2'b10 goes to RAM in every mode: mem_rd gives ram_rd and mem_wr gives ram_we.
- R2: With cfg_bank_info[7]=0 (16 KB scheme), an io_wr whose port (cpu_addr[7:0]) is FEh loads cpu_wdata into the window bank from the next cycle on. I/O writes to other ports change nothing.
- R3: A bank value v is legal only when cfg_start_bank <= v < cfg_start_bank + cfg_bank_info[6:0]. The sum is taken without wrap. An illegal value routes window reads to RAM (ram_rd) instead of ROM.
- R4: In the 16 KB scheme with a legal bank v, a window read raises rom_rd with rom_addr = (v - cfg_start_bank) * 16384 + cpu_addr[13:0].
- R5: In the 16 KB scheme with cfg_ram_mode=0, window writes to 9800h-988Fh raise snd_a_we and writes to B800h-B8AFh raise snd_b_we, whatever the bank. Other window writes raise ram_we while the bank is illegal and strobe nothing while it is legal.
- R6: In the 16 KB scheme with cfg_ram_mode=1 and an illegal bank, every window read and write goes to RAM, including the sound ranges. With a legal bank, reads go to ROM and writes behave as in R5.
- R7: With cfg_bank_info[7]=1 (8 KB scheme), a memory write to exactly 9000h loads the first-half bank and one to exactly B000h loads the second-half bank. These select writes strobe nothing. Port FEh has no effect in this scheme.
- R8: In the 8 KB scheme, 8000h-9FFFh uses the first-half bank and A000h-BFFFh uses the second-half bank. A legal bank v gives rom_addr = (v - cfg_start_bank) * 8192 + cpu_addr[12:0]. Writes to a half with a legal bank, outside the sound ranges and select addresses, strobe nothing; with an illegal bank they raise ram_we.
- R9: In the 8 KB scheme, writes to 9800h-988Fh raise snd_a_we and writes to B800h-B8AFh raise snd_b_we regardless of either bank, and cfg_ram_mode has no effect.
- R10: During reset and after it, until a select write, every bank register holds a no-bank state, so the whole window maps RAM.
- R11: For exclusive strobes, at most one of ram_rd, ram_we, rom_rd, snd_a_we and snd_b_we is high. An io_wr alone raises none of them. rom_addr is zero whenever rom_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address; the low byte is the port number on I/O cycles |
| cpu_wdata | input | 8 | CPU write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| cfg_start_bank | input | 8 | First bank number of the ROM image |
| cfg_bank_info | input | 8 | Bit 7: 8 KB scheme; bits 6:0: number of banks |
| cfg_ram_mode | input | 1 | Keeps the initial window area writable in the 16 KB scheme |
| ram_rd | output | 1 | Read is served by RAM |
| ram_we | output | 1 | Write goes to RAM |
| rom_rd | output | 1 | Read is served by ROM |
| rom_addr | output | 21 | Physical ROM byte address |
| snd_a_we | output | 1 | Register write strobe of the first sound chip |
| snd_b_we | output | 1 | Register write strobe of the enhanced sound chip |

## Verification
The assertions assume that mem_rd, mem_wr and io_wr are never high together, and that the configuration inputs stay still between resets. The bench drives at most one strobe per cycle and changes the configuration only while reset is applied. Its random phase biases write data toward the configured bank range and the select, sound and boundary addresses, so that legal, illegal and edge bank values all occur in both schemes.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  // window occupies cpu_addr[15:14] == 2'b10
  localparam logic [1:0]  WIN_TAG    = 2'b10;
  localparam logic [7:0]  PORT_BANK  = 8'hFE;
  localparam logic [15:0] SEL_LO     = 16'h9000;
  localparam logic [15:0] SEL_HI     = 16'hB000;
  localparam logic [15:0] SND_A_BASE = 16'h9800;
  localparam logic [15:0] SND_A_LAST = 16'h988F;
  localparam logic [15:0] SND_B_BASE = 16'hB800;
  localparam logic [15:0] SND_B_LAST = 16'hB8AF;

  // bank register slots
  localparam int SLOT_WIDE = 0;
  localparam int SLOT_LO   = 1;
  localparam int SLOT_HI   = 2;
  localparam int NUM_SLOTS = 3;

  typedef struct packed {
    logic ram_rd;
    logic ram_we;
    logic rom_rd;
    logic snd_a_we;
    logic snd_b_we;
  } route_t;

  function automatic logic in_span(input logic [15:0] a,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
  import mapper_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mode_narrow,
  input  logic                           io_wr,
  input  logic                           mem_wr,
  input  logic [15:0]                    cpu_addr,
  input  logic [BANK_W-1:0]              cpu_wdata,
  output logic [NUM_SLOTS-1:0][BANK_W-1:0] bank_val,
  output logic [NUM_SLOTS-1:0]           bank_set
);

  logic [NUM_SLOTS-1:0]              load_en;
  logic [NUM_SLOTS-1:0][BANK_W-1:0]  val_d;
  logic [NUM_SLOTS-1:0]              set_d;

  // select decode
  always_comb begin
    load_en            = '0;
    load_en[SLOT_WIDE] = io_wr && !mode_narrow && (cpu_addr[7:0] == PORT_BANK);
    load_en[SLOT_LO]   = mem_wr && mode_narrow && (cpu_addr == SEL_LO);
    load_en[SLOT_HI]   = mem_wr && mode_narrow && (cpu_addr == SEL_HI);
  end

  // next state per slot
  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_comb begin
        val_d[s] = bank_val[s];
        set_d[s] = bank_set[s];
        if (load_en[s]) begin
          val_d[s] = cpu_wdata;
          set_d[s] = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank_val[s] <= '0;
          bank_set[s] <= 1'b0;
        end else if (load_en[s]) begin
          bank_val[s] <= val_d[s];
          bank_set[s] <= set_d[s];
        end
      end
    end
  endgenerate

  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !mode_narrow && cpu_addr[7:0] == PORT_BANK)
      |=> (bank_set[SLOT_WIDE] && bank_val[SLOT_WIDE] == $past(cpu_wdata))); // R2

  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && cpu_addr[7:0] == PORT_BANK)
      |=> ($stable(bank_val[SLOT_WIDE]) && $stable(bank_set[SLOT_WIDE]))); // R2

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mode_narrow && cpu_addr == SEL_LO)
      |=> (bank_set[SLOT_LO] && bank_val[SLOT_LO] == $past(cpu_wdata))); // R7

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && cpu_addr == SEL_HI)
      |=> ($stable(bank_val[SLOT_HI]) && $stable(bank_set[SLOT_HI]))); // R7

endmodule

// File: rtl/mapper_bank_check.sv
module mapper_bank_check #(
  parameter int BANK_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic [BANK_W-1:0] val,
  input  logic              set,
  input  logic [BANK_W-1:0] start,
  input  logic [CNT_W-1:0]  count,
  output logic              legal,
  output logic [CNT_W-1:0]  idx
);

  localparam int EXT_W = BANK_W + 1;

  logic [EXT_W-1:0] v_ext;
  logic [EXT_W-1:0] lo_ext;
  logic [EXT_W-1:0] hi_ext;
  logic [BANK_W-1:0] diff;

  always_comb begin
    v_ext  = {1'b0, val};
    lo_ext = {1'b0, start};
    hi_ext = lo_ext + EXT_W'(count);
    legal  = set && (v_ext >= lo_ext) && (v_ext < hi_ext);
    diff   = val - start;
    idx    = legal ? diff[CNT_W-1:0] : '0;
  end

endmodule

// File: rtl/mapper_route.sv
module mapper_route
  import mapper_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ROM_AW = CNT_W + 14
) (
  input  logic [15:0]                   cpu_addr,
  input  logic                          mem_rd,
  input  logic                          mem_wr,
  input  logic                          mode_narrow,
  input  logic                          ram_mode,
  input  logic [NUM_SLOTS-1:0]          legal,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] idx,
  output route_t                        route,
  output logic [ROM_AW-1:0]             rom_addr
);

  logic             in_win;
  logic             upper_half;
  logic             hit_snd_a;
  logic             hit_snd_b;
  logic             hit_sel;
  logic             half_legal;
  logic [CNT_W-1:0] half_idx;

  always_comb begin
    in_win     = (cpu_addr[15:14] == WIN_TAG);
    upper_half = cpu_addr[13];
    hit_snd_a  = in_span(cpu_addr, SND_A_BASE, SND_A_LAST);
    hit_snd_b  = in_span(cpu_addr, SND_B_BASE, SND_B_LAST);
    hit_sel    = (cpu_addr == SEL_LO) || (cpu_addr == SEL_HI);
    half_legal = upper_half ? legal[SLOT_HI] : legal[SLOT_LO];
    half_idx   = upper_half ? idx[SLOT_HI]   : idx[SLOT_LO];
  end

  always_comb begin
    route    = '0;
    rom_addr = '0;
    if (!in_win) begin
      route.ram_rd = mem_rd;
      route.ram_we = mem_wr;
    end else if (mode_narrow) begin
      if (mem_rd) begin
        if (half_legal) begin
          route.rom_rd = 1'b1;
          rom_addr     = {1'b0, half_idx, cpu_addr[12:0]};
        end else begin
          route.ram_rd = 1'b1;
        end
      end
      if (mem_wr) begin
        if (hit_sel) begin
          route.snd_a_we = 1'b0;
        end else if (hit_snd_a) begin
          route.snd_a_we = 1'b1;
        end else if (hit_snd_b) begin
          route.snd_b_we = 1'b1;
        end else begin
          route.ram_we = !half_legal;
        end
      end
    end else begin
      if (mem_rd) begin
        if (legal[SLOT_WIDE]) begin
          route.rom_rd = 1'b1;
          rom_addr     = {idx[SLOT_WIDE], cpu_addr[13:0]};
        end else begin
          route.ram_rd = 1'b1;
        end
      end
      if (mem_wr) begin
        if (ram_mode && !legal[SLOT_WIDE]) begin
          route.ram_we = 1'b1;
        end else if (hit_snd_a) begin
          route.snd_a_we = 1'b1;
        end else if (hit_snd_b) begin
          route.snd_b_we = 1'b1;
        end else begin
          route.ram_we = !legal[SLOT_WIDE];
        end
      end
    end
  end

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import mapper_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int CNT_W  = 7,
  parameter int ROM_AW = CNT_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [BANK_W-1:0] cpu_wdata,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [BANK_W-1:0] cfg_start_bank,
  input  logic [CNT_W:0]    cfg_bank_info,
  input  logic              cfg_ram_mode,
  output logic              ram_rd,
  output logic              ram_we,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              snd_a_we,
  output logic              snd_b_we
);

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  logic                             mode_narrow;
  logic [CNT_W-1:0]                 bank_count;
  logic [NUM_SLOTS-1:0][BANK_W-1:0] bank_val;
  logic [NUM_SLOTS-1:0]             bank_set;
  logic [NUM_SLOTS-1:0]             legal;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]  idx;
  route_t                           route;

  assign mode_narrow = cfg_bank_info[CNT_W];
  assign bank_count  = cfg_bank_info[CNT_W-1:0];

  mapper_bank_regs #(.BANK_W(BANK_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .mode_narrow (mode_narrow),
    .io_wr       (io_wr),
    .mem_wr      (mem_wr),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .bank_val    (bank_val),
    .bank_set    (bank_set)
  );

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
      mapper_bank_check #(.BANK_W(BANK_W), .CNT_W(CNT_W)) i_chk (
        .val   (bank_val[s]),
        .set   (bank_set[s]),
        .start (cfg_start_bank),
        .count (bank_count),
        .legal (legal[s]),
        .idx   (idx[s])
      );
    end
  endgenerate

  mapper_route #(.CNT_W(CNT_W), .ROM_AW(ROM_AW)) i_route (
    .cpu_addr    (cpu_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mode_narrow (mode_narrow),
    .ram_mode    (cfg_ram_mode),
    .legal       (legal),
    .idx         (idx),
    .route       (route),
    .rom_addr    (rom_addr)
  );

  assign ram_rd   = route.ram_rd;
  assign ram_we   = route.ram_we;
  assign rom_rd   = route.rom_rd;
  assign snd_a_we = route.snd_a_we;
  assign snd_b_we = route.snd_b_we;

  AST_FIXED_RAM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_addr[15:14] != WIN_TAG && (mem_rd || mem_wr))
      |-> (!rom_rd && !snd_a_we && !snd_b_we && (ram_rd || ram_we))); // R1

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(mem_rd && mem_wr) |-> $onehot0({ram_rd, ram_we, rom_rd, snd_a_we, snd_b_we})); // R11

  AST_IO_SILENT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (io_wr && !mem_rd && !mem_wr)
      |-> ({ram_rd, ram_we, rom_rd, snd_a_we, snd_b_we} == 5'b0)); // R11

  AST_ROM_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    rom_rd |-> ({1'b0, rom_addr} < ({(ROM_AW+1)'(bank_count)} << (mode_narrow ? 13 : 14)))); // R4

  AST_NO_BANK_RAM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_rd && !mode_narrow && cpu_addr[15:14] == WIN_TAG && !bank_set[SLOT_WIDE])
      |-> (ram_rd && !rom_rd)); // R10

  AST_ROM_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rom_rd |-> (rom_addr == '0)); // R11

endmodule

// File: tb/test_bank_window_mapper.sv
module test_bank_window_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  cfg_start_bank = '0;
  logic [7:0]  cfg_bank_info = '0;
  logic        cfg_ram_mode = 1'b0;
  logic        ram_rd, ram_we, rom_rd, snd_a_we, snd_b_we;
  logic [20:0] rom_addr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state: -1 means no bank loaded
  int m_wide = -1;
  int m_lo = -1;
  int m_hi = -1;

  always #5 clk = ~clk;

  bank_window_mapper i_bank_window_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_wr(io_wr),
    .cfg_start_bank(cfg_start_bank), .cfg_bank_info(cfg_bank_info),
    .cfg_ram_mode(cfg_ram_mode), .ram_rd(ram_rd), .ram_we(ram_we),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .snd_a_we(snd_a_we), .snd_b_we(snd_b_we)
  );

  function automatic bit ok_bank(int v);
    int s = cfg_start_bank;
    int n = cfg_bank_info[6:0];
    return (v >= 0) && (v >= s) && (v < s + n);
  endfunction

  // expected {ram_rd, ram_we, rom_rd, snd_a, snd_b} and rom address
  function automatic logic [4:0] predict(int a, bit rd, bit wr, output int ra);
    bit narrow = cfg_bank_info[7];
    bit sa = (a >= 'h9800 && a <= 'h988F);
    bit sb = (a >= 'hB800 && a <= 'hB8AF);
    int b;
    ra = 0;
    if (a < 'h8000 || a >= 'hC000) return {rd, wr, 3'b000};
    if (narrow) begin
      b = (a >= 'hA000) ? m_hi : m_lo;
      if (rd) begin
        if (ok_bank(b)) begin
          ra = (b - cfg_start_bank) * 8192 + (a % 8192);
          return 5'b00100;
        end
        return 5'b10000;
      end
      if (wr) begin
        if (a == 'h9000 || a == 'hB000) return 5'b0;
        if (sa) return 5'b00010;
        if (sb) return 5'b00001;
        return ok_bank(b) ? 5'b0 : 5'b01000;
      end
      return 5'b0;
    end
    if (rd) begin
      if (ok_bank(m_wide)) begin
        ra = (m_wide - cfg_start_bank) * 16384 + (a % 16384);
        return 5'b00100;
      end
      return 5'b10000;
    end
    if (wr) begin
      if (cfg_ram_mode && !ok_bank(m_wide)) return 5'b01000;
      if (sa) return 5'b00010;
      if (sb) return 5'b00001;
      return ok_bank(m_wide) ? 5'b0 : 5'b01000;
    end
    return 5'b0;
  endfunction

  task automatic compare(input string tag);
    int ra;
    logic [4:0] exp_r = predict(cpu_addr, mem_rd, mem_wr, ra);
    logic [4:0] got_r = {ram_rd, ram_we, rom_rd, snd_a_we, snd_b_we};
    tests++;
    if (got_r !== exp_r) begin
      fails++;
      $display("FAIL %s route addr=%h got=%b exp=%b", tag, cpu_addr, got_r, exp_r);
    end
    tests++;
    if (rom_addr !== 21'(ra)) begin
      fails++;
      $display("FAIL %s rom_addr addr=%h got=%h exp=%h", tag, cpu_addr, rom_addr, 21'(ra));
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d,
                      input bit rd, input bit wr, input bit io, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; mem_rd = rd; mem_wr = wr; io_wr = io;
    #4;
    compare(tag);
    @(posedge clk);
    if (io && !cfg_bank_info[7] && a[7:0] == 8'hFE) m_wide = d;
    if (wr && cfg_bank_info[7] && a == 16'h9000) m_lo = d;
    if (wr && cfg_bank_info[7] && a == 16'hB000) m_hi = d;
    #1;
    mem_rd = 0; mem_wr = 0; io_wr = 0;
  endtask

  task automatic restart(input logic [7:0] st, input logic [7:0] info, input bit rm);
    @(negedge clk);
    rst_n = 0; mem_rd = 0; mem_wr = 0; io_wr = 0;
    cfg_start_bank = st; cfg_bank_info = info; cfg_ram_mode = rm;
    m_wide = -1; m_lo = -1; m_hi = -1;
    cpu_addr = 16'h8000; mem_rd = 1;
    #2;
    compare("R10"); // window read while reset held
    mem_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(a, 8'h00, 1, 0, 0, tag);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(a, d, 0, 1, 0, tag);
  endtask
  task automatic io(input logic [7:0] p, input logic [7:0] d, input string tag);
    step({8'h00, p}, d, 0, 0, 1, tag);
  endtask

  initial begin
    // 16 KB scheme, banks 4..6
    restart(8'd4, 8'h03, 0);
    rd(16'h8000, "R10");
    rd(16'h0000, "R1"); wr(16'h7FFF, 8'h11, "R1");
    rd(16'hC000, "R1"); wr(16'hFFFF, 8'h22, "R1");
    io(8'hFE, 8'd5, "R2");
    rd(16'h8123, "R4"); rd(16'hBFFF, "R4");
    wr(16'h9800, 8'h01, "R5"); wr(16'h988F, 8'h02, "R5");
    wr(16'h9890, 8'h03, "R5"); wr(16'hB8AF, 8'h04, "R5");
    wr(16'hB8B0, 8'h05, "R5");
    io(8'hFD, 8'd4, "R2"); rd(16'h8000, "R2");
    io(8'hFE, 8'd7, "R3"); rd(16'h8000, "R3");
    wr(16'h8000, 8'h06, "R5"); wr(16'h9800, 8'h07, "R5");
    io(8'hFE, 8'd3, "R3"); rd(16'hA000, "R3");
    io(8'hFE, 8'd6, "R3"); rd(16'h8001, "R3");
    io(8'hFE, 8'd0, "R11"); rd(16'h4000, "R11");

    // 16 KB scheme, RAM mode
    restart(8'd4, 8'h03, 1);
    wr(16'h9800, 8'h10, "R6"); rd(16'h9800, "R6"); wr(16'hB800, 8'h11, "R6");
    io(8'hFE, 8'd4, "R6");
    rd(16'h9800, "R6"); wr(16'h9800, 8'h12, "R6");
    wr(16'h8000, 8'h13, "R6"); wr(16'hB800, 8'h14, "R6");

    // 8 KB scheme, banks 10..14
    restart(8'd10, 8'h85, 0);
    rd(16'h8005, "R10"); rd(16'hA005, "R10");
    wr(16'h9000, 8'd11, "R7");
    rd(16'h8005, "R8"); rd(16'hA005, "R10");
    wr(16'hB000, 8'd14, "R7");
    rd(16'hBFFF, "R8"); rd(16'h9FFF, "R8");
    io(8'hFE, 8'd12, "R7"); rd(16'h8005, "R7");
    wr(16'h9800, 8'h20, "R9"); wr(16'hB8AF, 8'h21, "R9");
    wr(16'hA000, 8'h22, "R8"); wr(16'h8000, 8'h23, "R8");
    wr(16'h9000, 8'd15, "R3"); rd(16'h8000, "R3"); wr(16'h8000, 8'h24, "R8");
    rd(16'hB000, "R8");

    // 8 KB scheme with RAM-mode flag set
    restart(8'd10, 8'h85, 1);
    wr(16'h9800, 8'h30, "R9"); wr(16'hB800, 8'h31, "R9"); wr(16'h8100, 8'h32, "R9");

    // bank range reaching past 255
    restart(8'd250, 8'h0A, 0);
    io(8'hFE, 8'd255, "R3"); rd(16'h8010, "R3");
    io(8'hFE, 8'd0, "R3"); rd(16'h8010, "R3");
    io(8'hFE, 8'd249, "R3"); rd(16'h8010, "R3");

    // random traffic
    for (int blk = 0; blk < 8; blk++) begin
      logic [7:0] st = 8'($urandom_range(0, 255));
      logic [6:0] n = 7'($urandom_range(0, 127));
      bit nar = blk[0];
      restart(st, {nar, n}, blk[1]);
      for (int k = 0; k < 400; k++) begin
        int kind = $urandom_range(0, 9);
        int pick = $urandom_range(0, 9);
        logic [15:0] a;
        logic [7:0] d = 8'(int'(st) + $urandom_range(0, int'(n) + 2) - 1);
        case (pick)
          0: a = 16'h9000;
          1: a = 16'hB000;
          2: a = 16'(16'h9800 + $urandom_range(0, 16'h90));
          3: a = 16'(16'hB800 + $urandom_range(0, 16'hB0));
          4: a = 16'($urandom_range(0, 65535));
          5: a = 16'h00FE;
          default: a = 16'(16'h8000 + $urandom_range(0, 16'h3FFF));
        endcase
        if (kind < 4) step(a, d, 1, 0, 0, "R11");
        else if (kind < 8) step(a, d, 0, 1, 0, "R11");
        else step(a, d, 0, 0, 1, "R11");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule